// File: doc/BRIEF.md
# Prioritized Interrupt Cause and Status Unit

This unit is the interrupt bookkeeping that sits next to a processor's control path. It holds two architectural registers. The status register carries a global interrupt enable, an exception-level flag, a user-mode flag and an eight-bit interrupt mask. The cause register carries eight pending-interrupt bits, a five-bit exception code and a branch-delay flag. Six external interrupt lines drive the upper six pending bits. Software sets the lower two pending bits by writing the cause register.

Interrupts are examined only when the pipeline signals that a new instruction is starting, so an instruction that is already running is never aborted. In that cycle the unit raises `take_irq` if a pending source with its mask bit set exists, interrupts are globally enabled and the exception level is clear. `irq_idx` names the most significant such source. Taking the interrupt records exception code 0 and the delay-slot flag, and it sets the exception level, which keeps further interrupts out until software clears it. A synchronous internal exception reported by the pipeline takes precedence over an interrupt in the same cycle.

Top module: `irq_cause_unit`

## Requirements
- R1: Status register layout: bit 0 interrupt enable, bit 1 exception level, bit 4 user mode, bits 15:8 mask, all other bits read 0. A write with `reg_sel`=0 loads all four fields. Reset clears them.
- R2: Cause register layout: bits 15:8 pending, bits 6:2 exception code, bit 31 branch delay, all other bits read 0. `reg_rdata` returns the register chosen by `reg_sel` (0 status, 1 cause) in the same cycle. Reset clears every cause field.
- R3: With interrupt enable 0, `take_irq` stays 0 whatever the pending and mask bits are.
- R4: A pending bit can cause an interrupt only if the mask bit at the same position is 1.
- R5: When an interrupt is taken, exception level reads 1 from the next cycle on. While it is 1, `take_irq` stays 0.
- R6: Among pending and unmasked sources, the most significant one wins. `irq_idx` equals its cause bit position minus 8.
- R7: A write with `reg_sel`=1 changes only cause bits 9:8 (software pending), copying `reg_wdata[9:8]`. The other written bits have no effect.
- R8: Cause bits 15:10 follow `hw_irq[5:0]`, with each line sampled at every clock edge, so a level change shows on the next cycle.
- R9: `take_irq` rises only in a cycle where `insn_start` is 1, and it is decided in that same cycle from the register state.
- R10: Taking an interrupt writes exception code 0 and loads the branch-delay flag from `in_delay_slot`.
- R11: `exc_valid` loads the exception code from `exc_code`, sets exception level and loads the branch-delay flag. It suppresses `take_irq` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq | input | 6 | External interrupt levels |
| insn_start | input | 1 | A new instruction starts this cycle |
| in_delay_slot | input | 1 | That instruction sits in a branch delay slot |
| exc_valid | input | 1 | Internal exception reported this cycle |
| exc_code | input | 5 | Code of the internal exception |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 status, 1 cause |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| take_irq | output | 1 | Interrupt accepted at this instruction boundary |
| irq_idx | output | 3 | Winning source, 0 to 7 |

## Verification
The bench goes after the priority order when every source is pending at once. A reversed encoder would report source 0 instead of 7. It also checks masking of the top source alone, where a design that ignores the mask would pick a masked line. Cause writes carrying ones in the hardware and code positions are checked to leave those fields alone; a design that stores the whole write would corrupt them. An exception and an interrupt arriving in the same cycle are checked to see that the exception code wins and no interrupt is reported. A design that skips the exception-level block would take the same interrupt again on each following instruction, and the bench checks for that too.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int SRC_N   = 8;
  localparam int IDX_W   = $clog2(SRC_N);
  localparam int CODE_W  = 5;
  localparam int REG_W   = 32;
  // status field positions
  localparam int ST_IE   = 0;
  localparam int ST_EXL  = 1;
  localparam int ST_UM   = 4;
  localparam int MSK_LO  = 8;
  // cause field positions
  localparam int CA_CODE = 2;
  localparam int CA_BD   = 31;
  localparam logic [CODE_W-1:0] CODE_INT = '0;

  // index of the most significant set bit, 0 when none
  function automatic logic [IDX_W-1:0] top_bit(input logic [SRC_N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_unit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             set_exl,
  output logic [SRC_N-1:0] mask,
  output logic             user_mode,
  output logic             exl,
  output logic             ie
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask      <= '0;
      user_mode <= 1'b0;
      exl       <= 1'b0;
      ie        <= 1'b0;
    end else begin
      if (wr_en) begin
        mask      <= wdata[MSK_LO +: SRC_N];
        user_mode <= wdata[ST_UM];
        exl       <= wdata[ST_EXL];
        ie        <= wdata[ST_IE];
      end
      if (set_exl) exl <= 1'b1;
    end
  end

  // R5: an accepted event always leaves exception level set
  a_r5_exl_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_exl |=> exl);
  // R1: without a write or an event the fields hold
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !set_exl) |=> ($stable(mask) && $stable(ie) && $stable(exl) && $stable(user_mode)));
endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg
  import irq_unit_pkg::*;
#(
  parameter int NUM_HW = 6,
  parameter int NUM_SW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_HW-1:0] hw_irq,
  input  logic              sw_wr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              evt_irq,
  input  logic              evt_exc,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              in_delay,
  output logic [SRC_N-1:0]  pend,
  output logic [CODE_W-1:0] code,
  output logic              bd
);
  logic [NUM_HW-1:0] hw_q;
  logic [NUM_SW-1:0] sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hw_q <= '0;
    else        hw_q <= hw_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sw_q <= '0;
    else if (sw_wr) sw_q <= wdata[MSK_LO +: NUM_SW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
      bd   <= 1'b0;
    end else if (evt_exc) begin
      code <= exc_code;
      bd   <= in_delay;
    end else if (evt_irq) begin
      code <= CODE_INT;
      bd   <= in_delay;
    end
  end

  assign pend = {hw_q, sw_q};

  // R8: hardware pending bits track the lines one edge later
  a_r8_hw_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend[SRC_N-1:NUM_SW] == $past(hw_irq)));
  // R7: software bits move only on a cause write
  a_r7_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> $stable(pend[NUM_SW-1:0]));
  // R10: interrupt records code 0 and the delay flag
  a_r10_irq_code: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_irq && !evt_exc) |=> (code == CODE_INT && bd == $past(in_delay)));
  // R11: exception records its own code
  a_r11_exc_code: assert property (@(posedge clk) disable iff (!rst_n)
    evt_exc |=> (code == $past(exc_code)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_unit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] pend,
  input  logic [SRC_N-1:0] mask,
  input  logic             ie,
  input  logic             exl,
  input  logic             insn_start,
  input  logic             exc_valid,
  output logic             take,
  output logic [IDX_W-1:0] idx
);
  logic [SRC_N-1:0] live;
  logic             any_live;
  logic             gate_open;

  assign live      = pend & mask;
  assign any_live  = |live;
  assign gate_open = ie && !exl && !exc_valid;
  assign take      = insn_start && gate_open && any_live;
  assign idx       = top_bit(live);

  // R3: global enable low blocks everything
  a_r3_ie_block: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !take);
  // R4: winner must be pending and unmasked
  a_r4_masked_src: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (pend[idx] && mask[idx]));
  // R6: nothing above the winner is live
  a_r6_top_prio: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((live >> idx) == SRC_N'(1)));
  // R9: only at an instruction boundary
  a_r9_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> insn_start);
  // R11: exception suppresses the interrupt
  a_r11_exc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !take);
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
  import irq_unit_pkg::*;
#(
  parameter int NUM_HW = 6,
  parameter int NUM_SW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_HW-1:0] hw_irq,
  input  logic              insn_start,
  input  logic              in_delay_slot,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              take_irq,
  output logic [IDX_W-1:0]  irq_idx
);
  logic [SRC_N-1:0]  mask, pend;
  logic              user_mode, exl, ie, bd;
  logic [CODE_W-1:0] code;
  logic              st_wr, ca_wr, evt_any;
  logic [REG_W-1:0]  st_word, ca_word;

  assign st_wr   = reg_wr && !reg_sel;
  assign ca_wr   = reg_wr &&  reg_sel;
  assign evt_any = take_irq || exc_valid;

  irq_status_reg u_status (
    .clk(clk), .rst_n(rst_n), .wr_en(st_wr), .wdata(reg_wdata),
    .set_exl(evt_any), .mask(mask), .user_mode(user_mode),
    .exl(exl), .ie(ie)
  );

  irq_cause_reg #(.NUM_HW(NUM_HW), .NUM_SW(NUM_SW)) u_cause (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .sw_wr(ca_wr),
    .wdata(reg_wdata), .evt_irq(take_irq), .evt_exc(exc_valid),
    .exc_code(exc_code), .in_delay(in_delay_slot),
    .pend(pend), .code(code), .bd(bd)
  );

  irq_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask), .ie(ie),
    .exl(exl), .insn_start(insn_start), .exc_valid(exc_valid),
    .take(take_irq), .idx(irq_idx)
  );

  always_comb begin
    st_word = '0;
    st_word[ST_IE]  = ie;
    st_word[ST_EXL] = exl;
    st_word[ST_UM]  = user_mode;
    st_word[MSK_LO +: SRC_N] = mask;
    ca_word = '0;
    ca_word[MSK_LO +: SRC_N]  = pend;
    ca_word[CA_CODE +: CODE_W] = code;
    ca_word[CA_BD] = bd;
  end

  assign reg_rdata = reg_sel ? ca_word : st_word;

  // R5: after a taken interrupt no second one until software clears the level
  a_r5_no_retake: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && !st_wr) |=> !take_irq);
endmodule

// File: tb/irq_cause_unit_tb_top.sv
module irq_cause_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  hw_irq = '0;
  logic        insn_start = 1'b0, in_delay_slot = 1'b0, exc_valid = 1'b0;
  logic [4:0]  exc_code = '0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        take_irq;
  logic [2:0]  irq_idx;

  int checks = 0, errors = 0;

  // bench model state
  logic [7:0] m_mask; logic m_um, m_exl, m_ie;
  logic [5:0] m_hw;   logic [1:0] m_sw; logic [4:0] m_code; logic m_bd;

  always #2.5 clk = ~clk;

  irq_cause_unit dut_i (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .insn_start(insn_start),
    .in_delay_slot(in_delay_slot), .exc_valid(exc_valid), .exc_code(exc_code),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .take_irq(take_irq), .irq_idx(irq_idx)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] m_status();
    return {16'h0, m_mask, 3'b0, m_um, 2'b0, m_exl, m_ie};
  endfunction
  function automatic logic [31:0] m_cause();
    return {m_bd, 15'h0, m_hw, m_sw, 1'b0, m_code, 2'b0};
  endfunction
  // winner found by shifting down from the top, unlike a scan up
  function automatic logic [2:0] m_pick(input logic [7:0] v);
    logic [2:0] k = 3'd7;
    while (k != 0 && !v[7]) begin v = v << 1; k--; end
    return k;
  endfunction
  function automatic logic m_take();
    return insn_start && m_ie && !m_exl && !exc_valid && (({m_hw, m_sw} & m_mask) != 0);
  endfunction

  // one cycle: inputs already driven after a negedge
  task automatic step();
    logic et;
    string tg;
    #1;
    et = m_take();
    if (!m_ie) tg = "R3 take"; else if (m_exl) tg = "R5 take";
    else if (exc_valid) tg = "R11 take"; else if (!insn_start) tg = "R9 take";
    else tg = "R4 take";
    chk(tg, {31'b0, take_irq}, {31'b0, et});
    if (et) chk("R6 idx", {29'b0, irq_idx}, {29'b0, m_pick({m_hw, m_sw} & m_mask)});
    chk(reg_sel ? "R2 cause read" : "R1 status read", reg_rdata, reg_sel ? m_cause() : m_status());
    @(posedge clk);
    m_hw = hw_irq;
    if (reg_wr && !reg_sel) begin
      m_mask = reg_wdata[15:8]; m_um = reg_wdata[4]; m_exl = reg_wdata[1]; m_ie = reg_wdata[0];
    end
    if (reg_wr && reg_sel) m_sw = reg_wdata[9:8];
    if (exc_valid) begin m_exl = 1; m_code = exc_code; m_bd = in_delay_slot; end
    else if (et) begin m_exl = 1; m_code = 0; m_bd = in_delay_slot; end
    @(negedge clk);
    reg_wr = 0; insn_start = 0; exc_valid = 0;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d; step();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    m_mask = 0; m_um = 0; m_exl = 0; m_ie = 0; m_hw = 0; m_sw = 0; m_code = 0; m_bd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state R1 R2
    reg_sel = 0; #1 chk("R1 reset status", reg_rdata, 32'h0);
    reg_sel = 1; #1 chk("R2 reset cause", reg_rdata, 32'h0);
    @(negedge clk);
    // R3: all pending, mask full, ie off
    hw_irq = 6'h3F; wr(1, 32'h0000_0300);
    wr(0, 32'h0000_FF00);
    insn_start = 1; step();
    chk("R3 no take with ie low", {31'b0, take_irq}, 32'h0);
    // R6: everything pending, enable -> source 7
    wr(0, 32'h0000_FF01);
    insn_start = 1; #1 chk("R6 all pending picks 7", {29'b0, irq_idx}, 32'd7); step();
    // R5: exl now set, retake blocked
    reg_sel = 0; #1 chk("R5 exl set after take", {31'b0, reg_rdata[1]}, 32'h1);
    insn_start = 1; step();
    // R4: mask top off -> source 6
    wr(0, 32'h0000_7F01);
    insn_start = 1; #1 chk("R4 masked top picks 6", {29'b0, irq_idx}, 32'd6); step();
    // R7: cause write with garbage in hw/code/bd positions
    wr(0, 32'h0000_0301); hw_irq = 0; @(posedge clk); @(negedge clk); m_hw = 0;
    wr(1, 32'h8000_FC7C);
    reg_sel = 1; #1 chk("R7 only sw bits change", reg_rdata, {m_bd, 15'h0, 8'h00, 1'b0, m_code, 2'b0});
    wr(1, 32'h0000_0100);
    insn_start = 1; in_delay_slot = 1;
    #1 chk("R7 sw bit 0 taken idx", {29'b0, irq_idx}, 32'd0); step();
    in_delay_slot = 0;
    reg_sel = 1; #1 chk("R10 code 0 and bd set", reg_rdata, 32'h8000_0100);
    // R8: line level seen one edge later
    hw_irq = 6'h20; reg_sel = 1; #1 chk("R8 not yet visible", {24'h0, reg_rdata[15:8]}, 32'h01);
    step(); reg_sel = 1; #1 chk("R8 visible next cycle", {24'h0, reg_rdata[15:8]}, 32'h81);
    // R11: exception and interrupt together
    wr(0, 32'h0000_FF01);
    insn_start = 1; exc_valid = 1; exc_code = 5'd12; step();
    reg_sel = 1; #1 chk("R11 exc code recorded", {27'h0, reg_rdata[6:2]}, 32'd12);
    reg_sel = 0; #1 chk("R11 exl set", {31'b0, reg_rdata[1]}, 32'h1);
    // R9: no strobe no take
    wr(0, 32'h0000_FF01);
    #1 chk("R9 idle without strobe", {31'b0, take_irq}, 32'h0); step();
    // random phase
    for (int n = 0; n < 3000; n++) begin
      hw_irq = 6'($urandom);
      insn_start = $urandom_range(0, 1);
      in_delay_slot = $urandom_range(0, 1);
      exc_valid = ($urandom_range(0, 19) == 0);
      exc_code = 5'($urandom);
      reg_sel = $urandom_range(0, 1);
      reg_wr = ($urandom_range(0, 3) == 0);
      reg_wdata = $urandom;
      if (reg_wr && !reg_sel && $urandom_range(0, 1)) reg_wdata[1:0] = 2'b01;
      step();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule